// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the 256-byte configuration header of a single device function and serves it through a simple access port. Each access carries a 32-bit address: bits 23:16 select the bus, bits 15:8 the device-function and bits 7:0 the byte offset in the header. Bits 31:24 are not decoded. The function answers only when both the bus and the device-function fields equal its own numbers, which are set by parameters. A read to any other target returns all ones at the width of the access. A write to any other target is dropped.

Accesses are 1, 2 or 4 bytes wide and little-endian. A write is split into byte lanes, and each lane is checked against a read-only map. Two maps exist: one for ordinary functions and one for bridges, and the header-type parameter selects between them. A full-width write to an implemented base address register or to the expansion-ROM register takes a separate path. That path clears the address bits below the region's power-of-two size and forces back the fixed bits, so software can size a region by writing all ones and reading back the result. A one-cycle strobe tells a downstream window decoder that the command register or a region register has been touched.

Top module: `cfg_space`

## Requirements
- R1: After reset the header reads back as follows. Vendor ID is at 0x00–0x01, device ID at 0x02–0x03, the 24-bit class code at 0x09–0x0B, the header type at 0x0E and the interrupt pin at 0x3D. Each implemented base register holds its type bit in bit 0: 1 for I/O, 0 for memory. All other bytes are zero. Both `rd_valid` and `map_upd` are low.
- R2: The function is targeted only when address bits 23:16 equal `BUS_NO` and bits 15:8 equal `DEVFN`. A read to any other target returns all ones at the access width: 0xFF for size code 0, 0xFFFF for code 1, and 0xFFFFFFFF for codes 2 and 3. A write to any other target changes nothing.
- R3: A read request is answered on the cycle after it, with `rd_valid` high for exactly one cycle. Byte offset k lands at `rd_data[8k+7:8k]`, and unused upper bits are zero. Size codes: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes.
- R4: A 4-byte read at an offset above 0xFC returns 2 bytes if the offset is at most 0xFE, and 1 byte at 0xFF. A 2-byte read at 0xFF returns 1 byte.
- R5: When the header type is 0x00 or 0x80, the following bytes ignore writes: 0x00–0x03, 0x06–0x0B, 0x0E, 0x10–0x27, 0x2C–0x33 and 0x3D. This does not apply to the register path of R7 and R8.
- R6: For any other header type (the bridge layout, 0x01), the following bytes ignore writes: 0x00–0x03, 0x06–0x0B, 0x0E, 0x2C–0x2F, 0x38–0x3B and 0x3D. Offsets 0x10–0x27 and 0x30–0x33 take byte writes in this layout.
- R7: Consider a 4-byte write at offset 0x10 + 4·i to base register i whose size 2^L is non-zero. It stores (data AND NOT(2^L−1)) OR t, where t is 1 for an I/O region and 0 for a memory region. A register without a size falls back to the byte path.
- R8: A 4-byte write at 0x30 with a non-zero ROM size 2^L stores data AND (NOT(2^L−1) OR 1), so bit 0 keeps the ROM enable.
- R9: Every other write is applied lane by lane, from byte 0 of the data upward, to consecutive offsets. Lanes that would go past offset 0xFF are discarded and do not wrap around.
- R10: A byte write to offset 0x05 (the command high byte) stores only bits 2:0. Bits 7:3 read back as zero.
- R11: `map_upd` is high for exactly one cycle after a write to this function whose byte span, clipped at 0xFF, covers any of 0x04–0x05, 0x10–0x27 or 0x30–0x33. It stays low after every other access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Bus [23:16], device-function [15:8], offset [7:0] |
| acc_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| acc_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| map_upd | output | 1 | Command or region register was written |

## Verification
The bench builds two copies that share one access bus on bus 2.

The first copy is an ordinary function: header type 0x00, device-function 0x18, a 4 KiB memory base register 0, a 32-byte I/O base register 1, base registers 2–5 without a size, and a 64 KiB ROM. Together these cover the memory and I/O masking of R7, the byte-path fallback for a register without a size, and the ROM enable bit of R8.

The second copy uses the bridge layout (header type 0x01, device-function 0x20). Its presence makes every access to one copy an absent-target access for the other, and it exposes the offsets whose writability differs between the two layouts.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int CFG_BYTES = 256;
    localparam int MAX_BAR   = 6;
    localparam int LANES     = 4;

    localparam logic [7:0] CMD_HI_OFF  = 8'h05;
    localparam logic [7:0] CMD_HI_KEEP = 8'h07;
    localparam logic [7:0] ROM_OFF     = 8'h30;

    typedef logic [CFG_BYTES-1:0][7:0] cfg_mem_t;

    typedef struct packed {
        cfg_mem_t    mem;
        logic [31:0] rdata;
        logic        rvalid;
        logic        upd;
    } cfg_state_t;

    // bytes whose change must make the window decoder look again
    function automatic logic is_map_byte(input logic [7:0] a);
        return (a == 8'h04) || (a == 8'h05) ||
               (a >= 8'h10 && a <= 8'h27) ||
               (a >= 8'h30 && a <= 8'h33);
    endfunction

endpackage

// File: rtl/cfg_wrprot.sv
module cfg_wrprot #(
    parameter bit BRIDGE = 1'b0
) (
    input  logic [7:0] off,
    output logic       writable
);
    logic common_ro;
    logic layout_ro;

    assign common_ro = (off <= 8'h03) ||
                       (off >= 8'h06 && off <= 8'h0B) ||
                       (off == 8'h0E) ||
                       (off >= 8'h2C && off <= 8'h2F) ||
                       (off == 8'h3D);

    generate
        if (BRIDGE) begin : g_bridge
            assign layout_ro = (off >= 8'h38 && off <= 8'h3B);
        end else begin : g_func
            assign layout_ro = (off >= 8'h10 && off <= 8'h27) ||
                               (off >= 8'h30 && off <= 8'h33);
        end
    endgenerate

    assign writable = !(common_ro || layout_ro);
endmodule

// File: rtl/cfg_bar_mask.sv
module cfg_bar_mask #(
    parameter int                              NUM_BAR  = 6,
    parameter logic [6*cfg_pkg::MAX_BAR-1:0]   BAR_LOG2 = '0,
    parameter logic [cfg_pkg::MAX_BAR-1:0]     BAR_IO   = '0,
    parameter int                              ROM_LOG2 = 0
) (
    input  logic [7:0]  off,
    input  logic [31:0] wdata,
    output logic        hit,
    output logic [31:0] value
);
    logic [NUM_BAR:0]       hit_v;
    logic [NUM_BAR:0][31:0] val_v;

    for (genvar g = 0; g < NUM_BAR; g++) begin : g_bar
        localparam int          LG   = int'(BAR_LOG2[6*g +: 6]);
        localparam logic [31:0] KEEP = ~((32'd1 << LG) - 32'd1);
        localparam logic [7:0]  OFS  = 8'(16 + 4*g);
        if (LG != 0) begin : g_on
            assign hit_v[g] = (off == OFS);
            assign val_v[g] = (wdata & KEEP) | {31'd0, BAR_IO[g]};
        end else begin : g_off
            assign hit_v[g] = 1'b0;
            assign val_v[g] = '0;
        end
    end

    localparam logic [31:0] ROM_KEEP = ~((32'd1 << ROM_LOG2) - 32'd1) | 32'd1;
    generate
        if (ROM_LOG2 != 0) begin : g_rom
            assign hit_v[NUM_BAR] = (off == cfg_pkg::ROM_OFF);
            assign val_v[NUM_BAR] = wdata & ROM_KEEP;
        end else begin : g_norom
            assign hit_v[NUM_BAR] = 1'b0;
            assign val_v[NUM_BAR] = '0;
        end
    endgenerate

    always_comb begin
        hit   = |hit_v;
        value = '0;
        for (int i = 0; i <= NUM_BAR; i++) begin
            if (hit_v[i]) value = value | val_v[i];
        end
    end
endmodule

// File: rtl/cfg_space.sv
module cfg_space
    import cfg_pkg::*;
#(
    parameter logic [7:0]            BUS_NO     = 8'h02,
    parameter logic [7:0]            DEVFN      = 8'h18,
    parameter logic [7:0]            HDR_TYPE   = 8'h00,
    parameter logic [15:0]           VENDOR_ID  = 16'h1A2B,
    parameter logic [15:0]           DEVICE_ID  = 16'h3C4D,
    parameter logic [23:0]           CLASS_CODE = 24'h020000,
    parameter logic [7:0]            INT_PIN    = 8'h01,
    parameter int                    NUM_BAR    = 6,
    parameter logic [6*MAX_BAR-1:0]  BAR_LOG2   = {6'd0, 6'd0, 6'd0, 6'd0, 6'd5, 6'd12},
    parameter logic [MAX_BAR-1:0]    BAR_IO     = 6'b000010,
    parameter int                    ROM_LOG2   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [31:0] acc_addr,
    input  logic [1:0]  acc_size,
    input  logic [31:0] acc_wdata,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        map_upd
);
    localparam bit HDR_BRIDGE = (HDR_TYPE[6:0] != 7'd0);

    function automatic cfg_mem_t init_mem();
        cfg_mem_t m = '0;
        m[0]  = VENDOR_ID[7:0];
        m[1]  = VENDOR_ID[15:8];
        m[2]  = DEVICE_ID[7:0];
        m[3]  = DEVICE_ID[15:8];
        m[9]  = CLASS_CODE[7:0];
        m[10] = CLASS_CODE[15:8];
        m[11] = CLASS_CODE[23:16];
        m[14] = HDR_TYPE;
        m[61] = INT_PIN;
        for (int i = 0; i < NUM_BAR; i++) begin
            if (BAR_LOG2[6*i +: 6] != 6'd0) m[16 + 4*i] = {7'd0, BAR_IO[i]};
        end
        return m;
    endfunction

    localparam cfg_state_t RST_STATE = '{mem: init_mem(), rdata: 32'd0,
                                         rvalid: 1'b0, upd: 1'b0};

    cfg_state_t st_d, st_q;

    logic [7:0]  off;
    logic        hit_tgt;
    logic [2:0]  nbytes;
    logic        unused_hi;
    logic        bar_hit;
    logic [31:0] bar_val;
    logic [LANES-1:0][7:0] off_b;
    logic [LANES-1:0]      in_span;
    logic [LANES-1:0]      wr_ok;

    assign off       = acc_addr[7:0];
    assign hit_tgt   = (acc_addr[23:16] == BUS_NO) && (acc_addr[15:8] == DEVFN);
    assign nbytes    = (acc_size == 2'd0) ? 3'd1 : (acc_size == 2'd1) ? 3'd2 : 3'd4;
    assign unused_hi = ^acc_addr[31:24];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign off_b[g]   = off + 8'(g);
        assign in_span[g] = (3'(g) < nbytes) && (({1'b0, off} + 9'(g)) <= 9'd255);
        cfg_wrprot #(.BRIDGE(HDR_BRIDGE)) u_prot (
            .off      (off_b[g]),
            .writable (wr_ok[g])
        );
    end

    cfg_bar_mask #(
        .NUM_BAR  (NUM_BAR),
        .BAR_LOG2 (BAR_LOG2),
        .BAR_IO   (BAR_IO),
        .ROM_LOG2 (ROM_LOG2)
    ) u_bar (
        .off   (off),
        .wdata (acc_wdata),
        .hit   (bar_hit),
        .value (bar_val)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.upd    = 1'b0;

        if (acc_valid && !acc_write) begin
            st_d.rvalid = 1'b1;
            if (!hit_tgt) begin
                st_d.rdata = (nbytes == 3'd1) ? 32'h0000_00FF :
                             (nbytes == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
            end else if (nbytes == 3'd4 && off <= 8'hFC) begin
                st_d.rdata = {st_q.mem[off_b[3]], st_q.mem[off_b[2]],
                              st_q.mem[off_b[1]], st_q.mem[off_b[0]]};
            end else if (nbytes != 3'd1 && off <= 8'hFE) begin
                st_d.rdata = {16'd0, st_q.mem[off_b[1]], st_q.mem[off_b[0]]};
            end else begin
                st_d.rdata = {24'd0, st_q.mem[off]};
            end
        end

        if (acc_valid && acc_write && hit_tgt) begin
            for (int i = 0; i < LANES; i++) begin
                if (in_span[i] && is_map_byte(off_b[i])) st_d.upd = 1'b1;
            end
            if (nbytes == 3'd4 && bar_hit) begin
                for (int i = 0; i < LANES; i++) begin
                    st_d.mem[off_b[i]] = bar_val[8*i +: 8];
                end
            end else begin
                for (int i = 0; i < LANES; i++) begin
                    if (in_span[i] && wr_ok[i]) begin
                        st_d.mem[off_b[i]] = (off_b[i] == CMD_HI_OFF) ?
                            (acc_wdata[8*i +: 8] & CMD_HI_KEEP) : acc_wdata[8*i +: 8];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.rvalid;
    assign rd_data  = st_q.rdata;
    assign map_upd  = st_q.upd;
endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
    parameter logic [7:0] BUS_NO = 8'h02,
    parameter logic [7:0] DEVFN  = 8'h18
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [31:0] acc_addr,
    input logic [1:0]  acc_size,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        map_upd
);
    logic tgt;
    assign tgt = (acc_addr[23:16] == BUS_NO) && (acc_addr[15:8] == DEVFN);

    // R3
    rd_answers_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> rd_valid);

    // R3
    rd_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && !acc_write));

    // R11
    upd_only_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_upd |-> $past(acc_valid && acc_write && tgt));

    // R2
    absent_byte_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(acc_valid && !acc_write && !tgt && acc_size == 2'd0))
        |-> (rd_data == 32'h0000_00FF));

    // R4
    last_byte_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(acc_valid && !acc_write && tgt && acc_addr[7:0] == 8'hFF))
        |-> (rd_data[31:8] == 24'd0));

    // R10
    cmd_hi_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(acc_valid && !acc_write && tgt && acc_addr[7:0] == 8'h05
                           && acc_size == 2'd0))
        |-> (rd_data[7:3] == 5'd0));
endmodule

bind cfg_space cfg_space_chk #(.BUS_NO(BUS_NO), .DEVFN(DEVFN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .map_upd   (map_upd)
);

// File: tb/cfg_space_test.sv
module cfg_space_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic        rd_valid, map_upd, br_rd_valid, br_map_upd;
    logic [31:0] rd_data, br_rd_data;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfg_space uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .map_upd(map_upd)
    );

    cfg_space #(.HDR_TYPE(8'h01), .DEVFN(8'h20)) uut_br (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_valid(br_rd_valid), .rd_data(br_rd_data), .map_upd(br_map_upd)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference for the type-0 function -------------
    logic [7:0]  mm [256];
    logic        exp_rv, exp_up;
    logic [31:0] exp_rd;

    function automatic bit ro_func(input int a);
        return (a <= 3) || (a >= 6 && a <= 11) || a == 14 || (a >= 16 && a <= 39) ||
               (a >= 44 && a <= 51) || a == 61;
    endfunction

    function automatic bit touches(input int a);
        return a == 4 || a == 5 || (a >= 16 && a <= 39) || (a >= 48 && a <= 51);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mm[k]) mm[k] = 8'h00;
            mm[0] = 8'h2B; mm[1] = 8'h1A; mm[2] = 8'h4D; mm[3] = 8'h3C;
            mm[11] = 8'h02; mm[20] = 8'h01; mm[61] = 8'h01;
            exp_rv = 1'b0; exp_up = 1'b0; exp_rd = '0;
        end else begin
            exp_rv = 1'b0; exp_up = 1'b0;
            if (acc_valid) begin
                int n, o;
                bit tgt;
                logic [31:0] v;
                n = (acc_size == 0) ? 1 : (acc_size == 1) ? 2 : 4;
                o = int'(acc_addr[7:0]);
                tgt = acc_addr[23:16] == 8'h02 && acc_addr[15:8] == 8'h18;
                if (!acc_write) begin
                    exp_rv = 1'b1;
                    if (!tgt) exp_rd = (n == 1) ? 32'hFF : (n == 2) ? 32'hFFFF : 32'hFFFFFFFF;
                    else if (n == 4 && o <= 252)
                        exp_rd = {mm[o+3], mm[o+2], mm[o+1], mm[o]};
                    else if (n >= 2 && o <= 254) exp_rd = {16'd0, mm[o+1], mm[o]};
                    else exp_rd = {24'd0, mm[o]};
                end else if (tgt) begin
                    for (int k = 0; k < n; k++) if (o + k <= 255 && touches(o + k)) exp_up = 1'b1;
                    v = acc_wdata;
                    if (n == 4 && (o == 16 || o == 20 || o == 48)) begin
                        if (o == 16) v = v & ~32'd4095;
                        if (o == 20) v = (v & ~32'd31) | 32'd1;
                        if (o == 48) v = v & (~32'd65535 | 32'd1);
                        for (int k = 0; k < 4; k++) mm[o+k] = v[8*k +: 8];
                    end else begin
                        for (int k = 0; k < n; k++) begin
                            if (o + k <= 255 && !ro_func(o + k))
                                mm[o+k] = (o + k == 5) ? (v[8*k +: 8] & 8'h07) : v[8*k +: 8];
                        end
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("MODEL R3 rd_valid", {31'd0, rd_valid}, {31'd0, exp_rv});
            check("MODEL R11 map_upd", {31'd0, map_upd}, {31'd0, exp_up});
            if (exp_rv) check("MODEL R2 R3 R5 R7 R9 rd_data", rd_data, exp_rd);
        end
    end

    // ---------------- stimulus helpers -------------
    localparam logic [15:0] EP = 16'h0218;
    localparam logic [15:0] BR = 16'h0220;
    localparam logic [15:0] NX = 16'h0318;

    logic [31:0] r_ep, r_br;
    logic        u_ep, u_br;

    task automatic access(input bit wr, input logic [15:0] tgt, input logic [7:0] o,
                          input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = {8'h00, tgt, o};
        acc_size = sz; acc_wdata = wd;
        @(negedge clk);
        r_ep = rd_data; r_br = br_rd_data; u_ep = map_upd; u_br = br_map_upd;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd_ep(input logic [7:0] o, input logic [1:0] sz,
                         input logic [31:0] exp, input string tag);
        access(1'b0, EP, o, sz, 32'd0);
        check(tag, r_ep, exp);
    endtask

    task automatic rd_br(input logic [7:0] o, input logic [1:0] sz,
                         input logic [31:0] exp, input string tag);
        access(1'b0, BR, o, sz, 32'd0);
        check(tag, r_br, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
        check("R1 map_upd after reset", {31'd0, map_upd}, 32'd0);
        rd_ep(8'h00, 2'd2, 32'h3C4D1A2B, "R1 ids");
        rd_ep(8'h08, 2'd2, 32'h02000000, "R1 class");
        rd_ep(8'h0C, 2'd2, 32'h00000000, "R1 header type");
        rd_ep(8'h14, 2'd2, 32'h00000001, "R1 io bar type bit");
        rd_ep(8'h3C, 2'd2, 32'h00000100, "R1 int pin");
        rd_br(8'h0C, 2'd2, 32'h00010000, "R1 bridge header type");

        // R2 absent target
        access(1'b0, NX, 8'h00, 2'd0, 32'd0); check("R2 absent 1 byte", r_ep, 32'hFF);
        access(1'b0, NX, 8'h00, 2'd1, 32'd0); check("R2 absent 2 byte", r_ep, 32'hFFFF);
        access(1'b0, NX, 8'h00, 2'd3, 32'd0); check("R2 absent 4 byte", r_ep, 32'hFFFFFFFF);
        access(1'b1, NX, 8'h40, 2'd2, 32'hDEADBEEF);
        rd_ep(8'h40, 2'd2, 32'h0, "R2 absent write dropped");
        access(1'b1, BR, 8'h40, 2'd2, 32'h01020304);
        rd_ep(8'h40, 2'd2, 32'h0, "R2 other devfn write dropped");

        // R3 little-endian and width
        access(1'b1, EP, 8'h40, 2'd2, 32'hA1B2C3D4);
        rd_ep(8'h41, 2'd0, 32'h000000C3, "R3 byte lane");
        rd_ep(8'h42, 2'd1, 32'h0000A1B2, "R3 halfword");

        // R4 fallback and R9 stop at the top
        access(1'b1, EP, 8'hFC, 2'd2, 32'h11223344);
        rd_ep(8'hFD, 2'd2, 32'h00002233, "R4 wide read at FD");
        rd_ep(8'hFF, 2'd1, 32'h00000011, "R4 read at FF");
        access(1'b1, EP, 8'hFE, 2'd1, 32'h00005566);
        rd_ep(8'hFC, 2'd2, 32'h55663344, "R9 halfword write");
        access(1'b1, EP, 8'hFF, 2'd2, 32'hAABBCCDD);
        rd_ep(8'hFC, 2'd2, 32'hDD663344, "R9 last lane only");
        rd_ep(8'h00, 2'd2, 32'h3C4D1A2B, "R9 no wrap");

        // R5 read-only map, ordinary function
        access(1'b1, EP, 8'h00, 2'd2, 32'hFFFFFFFF);
        rd_ep(8'h00, 2'd2, 32'h3C4D1A2B, "R5 ids protected");
        access(1'b1, EP, 8'h3C, 2'd2, 32'hFFFFFFFF);
        rd_ep(8'h3C, 2'd2, 32'hFFFF01FF, "R5 int pin protected");
        access(1'b1, EP, 8'h2C, 2'd2, 32'h12345678);
        rd_ep(8'h2C, 2'd2, 32'h0, "R5 subsystem protected");
        access(1'b1, EP, 8'h11, 2'd0, 32'h000000AB);
        rd_ep(8'h10, 2'd2, 32'h0, "R5 bar byte protected");

        // R7 base registers
        access(1'b1, EP, 8'h10, 2'd2, 32'hFFFFFFFF);
        rd_ep(8'h10, 2'd2, 32'hFFFFF000, "R7 memory sizing");
        access(1'b1, EP, 8'h14, 2'd2, 32'hFFFFFFFF);
        rd_ep(8'h14, 2'd2, 32'hFFFFFFE1, "R7 io sizing");
        access(1'b1, EP, 8'h18, 2'd2, 32'hFFFFFFFF);
        rd_ep(8'h18, 2'd2, 32'h0, "R7 unsized register");
        access(1'b1, EP, 8'h10, 2'd2, 32'h12345678);
        rd_ep(8'h10, 2'd2, 32'h12345000, "R7 memory base");

        // R8 ROM
        access(1'b1, EP, 8'h30, 2'd2, 32'hFFFFFFFF);
        rd_ep(8'h30, 2'd2, 32'hFFFF0001, "R8 rom enable kept");
        access(1'b1, EP, 8'h30, 2'd2, 32'hFFFFFFFE);
        rd_ep(8'h30, 2'd2, 32'hFFFF0000, "R8 rom disabled");

        // R10 command high byte
        access(1'b1, EP, 8'h04, 2'd1, 32'h0000FFFF);
        check("R11 command write strobe", {31'd0, u_ep}, 32'd1);
        rd_ep(8'h04, 2'd1, 32'h000007FF, "R10 command mask");

        // R11 strobe
        access(1'b1, EP, 8'h40, 2'd0, 32'h5A);
        check("R11 no strobe plain byte", {31'd0, u_ep}, 32'd0);
        access(1'b1, EP, 8'h2E, 2'd2, 32'h0);
        check("R11 strobe span into rom", {31'd0, u_ep}, 32'd1);
        access(1'b1, EP, 8'h0E, 2'd2, 32'h0);
        check("R11 strobe span into bar", {31'd0, u_ep}, 32'd1);
        access(1'b1, NX, 8'h04, 2'd0, 32'h1);
        check("R11 no strobe absent", {31'd0, u_ep}, 32'd0);

        // R6 bridge layout
        access(1'b1, BR, 8'h11, 2'd0, 32'h000000AB);
        check("R11 bridge strobe", {31'd0, u_br}, 32'd1);
        rd_br(8'h10, 2'd2, 32'h0000AB00, "R6 bridge bar byte writable");
        access(1'b1, BR, 8'h38, 2'd2, 32'hFFFFFFFF);
        rd_br(8'h38, 2'd2, 32'h0, "R6 bridge 38 protected");
        access(1'b1, BR, 8'h31, 2'd0, 32'h0000005A);
        rd_br(8'h30, 2'd2, 32'h00005A00, "R6 bridge 30 byte writable");
        access(1'b1, BR, 8'h3C, 2'd1, 32'h0000FFFF);
        rd_br(8'h3C, 2'd1, 32'h000001FF, "R6 bridge int pin protected");
        access(1'b1, BR, 8'h10, 2'd2, 32'hFFFFFFFF);
        rd_br(8'h10, 2'd2, 32'hFFFFF000, "R7 bridge bar sizing");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule